// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming frames into memory by walking a circular list of receive descriptors that software prepares. A descriptor is four consecutive 32-bit words. Word 0 holds command and status flags. Word 1 carries the buffer capacity in its upper half and the stored byte count in its lower half. Word 2 points at the data buffer, and word 3 points at the next descriptor. Software sets the last descriptor's link back to the first, which closes the ring. The engine reads a descriptor and checks that the ownership flag hands it to the hardware. It then streams frame words into the buffer. Last, it writes back the count and a status word that returns the descriptor to software, and moves to the linked descriptor.

Software loads the ring start into the current-descriptor pointer while the engine is stopped, then starts it with an enable pulse. A descriptor still held by software halts the engine and raises a resource-error cause. A frame that shows up while the engine is halted is drained and reported as an overrun. An abort pulse halts the engine in the same cycle, with no write-back. Frame words are 32 bits wide and each one counts as four bytes.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the engine is stopped (`running` low), `in_ready` is high, `mem_req` is low, `cur_ptr` is 0 and all three cause outputs are low.
- R2: A `base_load` pulse while stopped copies `base_addr` into `cur_ptr`. An `rx_enable` pulse while stopped starts the engine, which reads the four descriptor words at `cur_ptr`, `cur_ptr`+4, +8 and +12.
- R3: If bit 31 (ownership, 1 = hardware) of descriptor word 0 is 0, the engine pulses `cause_reserr` once, stops, writes nothing, and leaves `cur_ptr` on that descriptor. A later enable reads the same descriptor again.
- R4: Accepted frame words are written in order to the buffer address plus the byte offset, and the offset grows by 4 per stored word.
- R5: After the last word of a frame, the engine writes word 1 of the descriptor as {capacity[31:16], stored byte count[15:0]}, then writes word 0 in the following write.
- R6: The written word 0 is the fetched word 0 with bit 31 cleared, bit 17 (first) and bit 16 (last) set, and bit 15 (error summary) equal to the truncation flag. All other bits keep their fetched values.
- R7: A word that would push the stored count past the capacity is accepted but not written, and it sets the error-summary bit. A frame that fills the buffer exactly completes without error.
- R8: `cause_done` pulses for one cycle after a completed descriptor whose bit 23 (interrupt enable) is set, and stays low when that bit is 0.
- R9: After a completion, `cur_ptr` takes the link from word 3, so the engine follows the ring around its wrap.
- R10: While stopped, `in_ready` is high and frame words are discarded. The first word of each such frame causes one `cause_overrun` pulse.
- R11: `rx_abort` stops the engine in the cycle it is high. That cycle issues no memory request, and a word accepted in that cycle is discarded. No count or status is written. The rest of the cut frame is drained without an overrun. Re-enabling reads the same descriptor again and restarts the byte offset at 0.
- R12: When `rx_abort` and `rx_enable` are high in the same cycle, the abort wins and the engine stays stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Start pulse, acts while stopped |
| rx_abort | input | 1 | Immediate stop pulse |
| base_load | input | 1 | Load ring start into the current pointer while stopped |
| base_addr | input | AW | Ring start address |
| in_valid | input | 1 | Frame word valid |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Marks the final word of a frame |
| in_ready | output | 1 | Frame word accepted when high together with in_valid |
| mem_req | output | 1 | Memory access request, always granted |
| mem_we | output | 1 | 1 = write, 0 = read (read data one cycle later) |
| mem_addr | output | AW | Byte address of the 32-bit access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| cur_ptr | output | AW | Current descriptor pointer |
| running | output | 1 | High while the engine is not stopped |
| cause_done | output | 1 | Frame-done cause pulse |
| cause_reserr | output | 1 | Resource-error cause pulse |
| cause_overrun | output | 1 | Overrun cause pulse |

## Verification
Two collisions are tested. In the first, an abort arrives in the same cycle that a frame word is accepted into a live buffer. The bench raises `rx_abort` together with the second word of a frame. It then expects the stored first word and nothing else: no count or status write, no done pulse, and no overrun for the remaining words of that frame. In the second, enable and abort arrive together. The engine must stay stopped with no memory request. A behavioural model of memory writes and causes is compared every clock. This confirms that the next enable reads the same descriptor again and stores data from offset 0.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int BEAT_BYTES = 4;
    // bit positions inside descriptor word 0; software decodes these
    localparam int OWN_B   = 31;
    localparam int IE_B    = 23;
    localparam int FIRST_B = 17;
    localparam int LAST_B  = 16;
    localparam int ERR_B   = 15;

    typedef enum logic [2:0] {
        S_STOP  = 3'd0,
        S_FETCH = 3'd1,
        S_RECV  = 3'd2,
        S_WCNT  = 3'd3,
        S_WSTAT = 3'd4
    } rx_state_e;
endpackage

// File: rtl/rxr_fill.sv
`timescale 1ns/1ps
module rxr_fill
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             beat,
    input  logic [CNT_W-1:0] cap,
    output logic [CNT_W-1:0] cnt,
    output logic             fits,
    output logic             trunc
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             trunc;
    } fill_t;

    fill_t d, q;
    logic [CNT_W:0] sum;

    always_comb begin
        sum  = {1'b0, q.cnt} + (CNT_W+1)'(BEAT_BYTES);
        fits = (sum <= {1'b0, cap});
        d    = q;
        if (clr) begin
            d = '0;
        end else if (beat) begin
            if (fits) d.cnt   = sum[CNT_W-1:0];
            else      d.trunc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt   = q.cnt;
    assign trunc = q.trunc;

    // R7
    cnt_in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> (q.cnt <= cap));
    // R7
    trunc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.trunc) |-> $past(clr));
endmodule

// File: rtl/rxr_frame_track.sv
`timescale 1ns/1ps
module rxr_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic last,
    input  logic stopped,
    output logic ovr
);
    typedef struct packed {
        logic sof;
        logic ovr;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d     = q;
        d.ovr = beat & q.sof & stopped;
        if (beat) d.sof = last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{sof: 1'b1, ovr: 1'b0};
        else        q <= d;
    end

    assign ovr = q.ovr;

    // R10
    ovr_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> ($past(stopped) && $past(beat)));
endmodule

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              abort,
    input  logic              base_load,
    input  logic [AW-1:0]     base_addr,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [WORD_W-1:0] in_data,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              fits,
    input  logic              trunc,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              fill_clr,
    output logic              fill_beat,
    output logic [CNT_W-1:0]  cap,
    output logic              stopped,
    output logic [AW-1:0]     cur_ptr,
    output logic              done,
    output logic              rerr
);
    typedef struct packed {
        rx_state_e         st;
        logic [1:0]        idx;
        logic              pend;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     bufp;
        logic [AW-1:0]     nxt;
        logic [WORD_W-1:0] cmd;
        logic [CNT_W-1:0]  cap;
        logic              done;
        logic              rerr;
    } ctrl_t;

    ctrl_t d, q;
    logic [WORD_W-1:0] stat;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.rerr    = 1'b0;
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fill_clr  = 1'b0;
        fill_beat = 1'b0;

        stat          = q.cmd;
        stat[OWN_B]   = 1'b0;
        stat[FIRST_B] = 1'b1;
        stat[LAST_B]  = 1'b1;
        stat[ERR_B]   = trunc;

        unique case (q.st)
            S_STOP: begin
                in_ready = 1'b1;
                if (base_load) d.cur = base_addr;
                if (en) begin
                    d.st   = S_FETCH;
                    d.idx  = '0;
                    d.pend = 1'b0;
                end
            end
            S_FETCH: begin
                if (!q.pend) begin
                    mem_req  = 1'b1;
                    mem_addr = q.cur + AW'({q.idx, 2'b00});
                    d.pend   = 1'b1;
                end else begin
                    d.pend = 1'b0;
                    d.idx  = q.idx + 2'd1;
                    case (q.idx)
                        2'd0: begin
                            d.cmd = mem_rdata;
                            if (!mem_rdata[OWN_B]) begin
                                d.rerr = 1'b1;
                                d.st   = S_STOP;
                                d.idx  = '0;
                            end
                        end
                        2'd1:    d.cap  = mem_rdata[WORD_W-1 -: CNT_W];
                        2'd2:    d.bufp = mem_rdata[AW-1:0];
                        default: begin
                            d.nxt    = mem_rdata[AW-1:0];
                            d.st     = S_RECV;
                            fill_clr = 1'b1;
                        end
                    endcase
                end
            end
            S_RECV: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    fill_beat = 1'b1;
                    if (fits) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = q.bufp + AW'(cnt);
                        mem_wdata = in_data;
                    end
                    if (in_last) d.st = S_WCNT;
                end
            end
            S_WCNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur + AW'(4);
                mem_wdata = {q.cap, cnt};
                d.st      = S_WSTAT;
            end
            S_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur;
                mem_wdata = stat;
                d.done    = q.cmd[IE_B];
                d.cur     = q.nxt;
                d.st      = S_FETCH;
                d.idx     = '0;
                d.pend    = 1'b0;
            end
            default: d.st = S_STOP;
        endcase

        if (abort) begin
            d.st      = S_STOP;
            d.pend    = 1'b0;
            d.idx     = '0;
            d.done    = 1'b0;
            d.rerr    = 1'b0;
            d.cur     = (q.st == S_STOP && base_load) ? base_addr : q.cur;
            mem_req   = 1'b0;
            mem_we    = 1'b0;
            fill_beat = 1'b0;
            fill_clr  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cap     = q.cap;
    assign stopped = (q.st == S_STOP);
    assign cur_ptr = q.cur;
    assign done    = q.done;
    assign rerr    = q.rerr;

    // R4
    in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && q.st == S_RECV) |-> ((mem_addr - q.bufp) < AW'(q.cap)));
    // R3
    reserr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rerr |-> stopped);
    // R11
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !mem_req);
    // R8
    one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.done, q.rerr}));
endmodule

// File: rtl/rx_ring_dma.sv
`timescale 1ns/1ps
module rx_ring_dma
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          rx_abort,
    input  logic          base_load,
    input  logic [AW-1:0] base_addr,
    input  logic          in_valid,
    input  logic [31:0]   in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [AW-1:0] cur_ptr,
    output logic          running,
    output logic          cause_done,
    output logic          cause_reserr,
    output logic          cause_overrun
);
    logic [CNT_W-1:0] cnt, cap;
    logic             fits, trunc, fill_clr, fill_beat, stopped;

    rxr_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_enable),
        .abort     (rx_abort),
        .base_load (base_load),
        .base_addr (base_addr),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_data   (in_data),
        .mem_rdata (mem_rdata),
        .cnt       (cnt),
        .fits      (fits),
        .trunc     (trunc),
        .in_ready  (in_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fill_clr  (fill_clr),
        .fill_beat (fill_beat),
        .cap       (cap),
        .stopped   (stopped),
        .cur_ptr   (cur_ptr),
        .done      (cause_done),
        .rerr      (cause_reserr)
    );

    rxr_fill u_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fill_clr),
        .beat  (fill_beat),
        .cap   (cap),
        .cnt   (cnt),
        .fits  (fits),
        .trunc (trunc)
    );

    rxr_frame_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (in_valid & in_ready),
        .last    (in_last),
        .stopped (stopped),
        .ovr     (cause_overrun)
    );

    assign running = ~stopped;
endmodule

// File: tb/rx_ring_dma_tb.sv
`timescale 1ns/1ps
module rx_ring_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0, rx_abort = 1'b0, base_load = 1'b0;
    logic [31:0] base_addr = '0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_ptr;
    logic        running, cause_done, cause_reserr, cause_overrun;

    always #2.5 clk = ~clk;

    rx_ring_dma u_dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_abort(rx_abort),
        .base_load(base_load), .base_addr(base_addr), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_ptr(cur_ptr),
        .running(running), .cause_done(cause_done),
        .cause_reserr(cause_reserr), .cause_overrun(cause_overrun)
    );

    // memory model, one-cycle read latency
    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [63:0] exp_wr[$];
    int          exp_cause[$];   // 0 done, 1 reserr, 2 overrun

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic see_cause(input int kind);
        int e;
        if (exp_cause.size() == 0) begin
            chk(1'b0, "R8 unexpected cause", kind, 32'hFFFF_FFFF);
        end else begin
            e = exp_cause.pop_front();
            chk(e == kind, "R8 cause order", kind, e);
        end
    endtask

    // per-clock comparison against the reference stream
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_req && mem_we) begin
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [63:0] e;
                    e = exp_wr.pop_front();
                    chk(mem_addr == e[63:32], "R5 write address", mem_addr, e[63:32]);
                    chk(mem_wdata == e[31:0], "R6 write data", mem_wdata, e[31:0]);
                end
            end
            if (cause_done)    see_cause(0);
            if (cause_reserr)  see_cause(1);
            if (cause_overrun) see_cause(2);
        end
    end

    function automatic logic [31:0] word_of(input int seed, input int k);
        return {16'(seed), 16'(k)};
    endfunction

    task automatic put_desc(input int a, input logic [31:0] cmd, input int cap,
                            input int bufa, input int nxt);
        mem[a/4]     = cmd;
        mem[a/4 + 1] = {16'(cap), 16'h0};
        mem[a/4 + 2] = 32'(bufa);
        mem[a/4 + 3] = 32'(nxt);
    endtask

    // reference model of one completed descriptor
    task automatic expect_frame(input int a, input logic [31:0] cmd, input int cap,
                                input int bufa, input int seed, input int n);
        int stored = 0;
        logic [31:0] st;
        for (int k = 0; k < n; k++) begin
            if (4 * (k + 1) <= cap) begin
                exp_wr.push_back({32'(bufa + 4 * k), word_of(seed, k)});
                stored = stored + 4;
            end
        end
        exp_wr.push_back({32'(a + 4), 16'(cap), 16'(stored)});
        st = cmd;
        st[31] = 1'b0;
        st[17] = 1'b1;
        st[16] = 1'b1;
        st[15] = (4 * n > cap);
        exp_wr.push_back({32'(a), st});
        if (cmd[23]) exp_cause.push_back(0);
    endtask

    task automatic send_frame(input int seed, input int n);
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_data  = word_of(seed, k);
            in_last  = (k == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_enable();
        rx_enable = 1'b1;
        @(negedge clk);
        rx_enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] IE  = 32'h0080_0000;
    logic [31:0] c0, c1, c2;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        c0 = OWN | IE | 32'h0000_00A5;
        c1 = OWN | IE | 32'h0000_003C;
        c2 = OWN | 32'h0000_0001;
        put_desc(32'h00, c0, 32, 32'h100, 32'h10);
        put_desc(32'h10, c1, 16, 32'h180, 32'h20);
        put_desc(32'h20, c2, 64, 32'h200, 32'h00);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(running == 1'b0, "R1 running", 32'(running), 0);
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 1);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        chk(cur_ptr == 32'h0, "R1 cur_ptr", cur_ptr, 0);
        chk({cause_done, cause_reserr, cause_overrun} == 3'b0, "R1 causes",
            32'({cause_done, cause_reserr, cause_overrun}), 0);

        // R10 frame while stopped
        exp_cause.push_back(2);
        send_frame(9, 2);
        idle(3);
        chk(exp_cause.size() == 0, "R10 overrun seen", exp_cause.size(), 0);

        // R2 base load while stopped
        base_load = 1'b1; base_addr = 32'h40;
        @(negedge clk);
        base_load = 1'b0;
        chk(cur_ptr == 32'h40, "R2 base load", cur_ptr, 32'h40);

        // R12 abort beats enable
        rx_enable = 1'b1; rx_abort = 1'b1;
        @(negedge clk);
        rx_enable = 1'b0; rx_abort = 1'b0;
        chk(running == 1'b0, "R12 stays stopped", 32'(running), 0);
        idle(2);
        chk(mem_req == 1'b0, "R12 no access", 32'(mem_req), 0);

        // R2 load ring start and run
        base_load = 1'b1; base_addr = 32'h00; rx_enable = 1'b1;
        @(negedge clk);
        base_load = 1'b0; rx_enable = 1'b0;
        chk(running == 1'b1, "R2 running", 32'(running), 1);
        chk(cur_ptr == 32'h00, "R2 cur_ptr", cur_ptr, 0);

        // R4 R5 R6 R8 plain frame
        expect_frame(32'h00, c0, 32, 32'h100, 1, 3);
        send_frame(1, 3);
        idle(12);
        chk(cur_ptr == 32'h10, "R9 follow link", cur_ptr, 32'h10);

        // R7 truncation
        expect_frame(32'h10, c1, 16, 32'h180, 2, 6);
        send_frame(2, 6);
        idle(12);
        chk(cur_ptr == 32'h20, "R9 follow link", cur_ptr, 32'h20);

        // R8 no interrupt enable; R3 ring wraps onto a software-held descriptor
        expect_frame(32'h20, c2, 64, 32'h200, 3, 1);
        exp_cause.push_back(1);
        send_frame(3, 1);
        idle(15);
        chk(running == 1'b0, "R3 stopped", 32'(running), 0);
        chk(cur_ptr == 32'h00, "R3 R9 wrap pointer", cur_ptr, 0);
        chk(exp_cause.size() == 0, "R3 reserr seen", exp_cause.size(), 0);

        // R10 again after resource error
        exp_cause.push_back(2);
        send_frame(4, 1);
        idle(3);
        chk(exp_cause.size() == 0, "R10 overrun seen", exp_cause.size(), 0);

        // software returns descriptors; R3 re-enable reads the same one
        put_desc(32'h00, c0, 32, 32'h100, 32'h10);
        put_desc(32'h10, c1, 16, 32'h180, 32'h20);
        put_desc(32'h20, c2, 64, 32'h200, 32'h00);
        pulse_enable();
        // R7 exact fit, no error
        expect_frame(32'h00, c0, 32, 32'h100, 5, 8);
        send_frame(5, 8);
        idle(12);
        chk(cur_ptr == 32'h10, "R9 follow link", cur_ptr, 32'h10);

        // R11 abort with an accepted word
        exp_wr.push_back({32'h180, word_of(6, 0)});
        in_valid = 1'b1; in_data = word_of(6, 0); in_last = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_data = word_of(6, 1);
        rx_abort = 1'b1;
        chk(in_ready == 1'b1, "R11 word offered", 32'(in_ready), 1);
        @(negedge clk);
        rx_abort = 1'b0;
        chk(running == 1'b0, "R11 stopped", 32'(running), 0);
        in_data = word_of(6, 2);
        @(negedge clk);
        in_data = word_of(6, 3); in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        idle(4);
        chk(cur_ptr == 32'h10, "R11 pointer kept", cur_ptr, 32'h10);
        chk(exp_wr.size() == 0, "R11 only first word", exp_wr.size(), 0);
        chk(exp_cause.size() == 0, "R11 no overrun", exp_cause.size(), 0);

        // R11 re-enable restarts on the same descriptor at offset 0
        pulse_enable();
        expect_frame(32'h10, c1, 16, 32'h180, 7, 2);
        send_frame(7, 2);
        idle(12);
        chk(cur_ptr == 32'h20, "R11 R9 after restart", cur_ptr, 32'h20);

        idle(5);
        chk(exp_wr.size() == 0, "R5 writes drained", exp_wr.size(), 0);
        chk(exp_cause.size() == 0, "R8 causes drained", exp_cause.size(), 0);
        finish_run();
    end
endmodule